// File: doc/BRIEF.md
# Bus Target Latency Disconnect Timer

This block measures how long a bus target keeps a transaction waiting for its next data phase and raises a disconnect request when a programmable budget runs out. Two limits exist. One applies to the first data phase of a transaction and the other to every later data phase. Each limit has its own configuration register.

A mode input tells the timer whether the bridge clocks are related (synchronous) or unrelated (asynchronous). In asynchronous mode a fixed clock offset is added to each programmed value. Only a small programmed range is accepted in that mode. Larger writes are clamped, and a sticky flag records that a clamp happened.

The surrounding bus logic supplies a transaction-active level and a strobe for each completed data phase. It uses the one-cycle disconnect request to end the transaction.

Top module: `tdt_latency_timer`

## Requirements
- R1: After reset, the subsequent-phase register reads 1, the initial-phase register reads 2, the clamp flag is 0 and the disconnect request is 0.
- R2: A write with `cfgWrEn` high goes to the subsequent-phase register when `cfgSelInit` is 0 and to the initial-phase register when it is 1. The new value is visible on the readback port in the next cycle.
- R3: In synchronous mode, with subsequent value V, a `phaseDone` strobe in cycle t is followed by `discReq` in cycle t+1+V, if no other phase completes first. This includes V = 0.
- R4: In asynchronous mode, with subsequent value V, a `phaseDone` strobe in cycle t is followed by `discReq` in cycle t+1+V+3.
- R5: In synchronous mode, if a transaction starts in cycle t (`xferActive` rises), `discReq` follows in cycle t+1+I, where I is the initial-phase register value.
- R6: In asynchronous mode, the initial limit is I+14. A setting of 2 therefore gives a disconnect 16 clocks after the count starts, in cycle t+1+16.
- R7: In asynchronous mode, a write of a value above 2 to either register stores 2 and sets `clampSticky`. The flag stays set until reset. Synchronous-mode writes are stored unchanged and never set the flag.
- R8: `discReq` is high for exactly one cycle per data phase. It stays low until the next start or `phaseDone`.
- R9: While `xferActive` is low, `discReq` stays low and the count is held at zero. Idle time before a transaction does not shorten its first limit.
- R10: `discReq` is not raised in a cycle in which `phaseDone` is high. That strobe restarts the count for the next phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncMode | input | 1 | 1 = synchronous bridge, 0 = asynchronous bridge |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSelInit | input | 1 | Write target: 0 = subsequent-phase limit, 1 = initial-phase limit |
| cfgWrData | input | VAL_W | Value to write |
| xferActive | input | 1 | High while a transaction is in progress |
| phaseDone | input | 1 | One-cycle strobe when a data phase completes |
| discReq | output | 1 | One-cycle disconnect request |
| clampSticky | output | 1 | Set when an asynchronous-mode write was clamped |
| subLatVal | output | VAL_W | Stored subsequent-phase limit |
| initLatVal | output | VAL_W | Stored initial-phase limit |

## Verification
The bench builds the timer with its default parameters: a 5-bit value field, offsets of 3 and 14 clocks, and an asynchronous ceiling of 2. These values bring the 16-clock initial limit of asynchronous mode, a zero-length subsequent limit, and a synchronous value of 9 (above the ceiling) within a short run. With the narrow field, a clamped write and an unclamped write of the same large value can be compared directly. Expected disconnect cycles are queued from the requirement formulas, so an early, late, missing or repeated pulse is detected.

// File: rtl/tdt_pkg.sv
package tdt_pkg;

  // Strobes passed from the control FSM to the counting datapath.
  typedef struct packed {
    logic clrCnt;   // force the wait counter to zero
    logic incCnt;   // advance the wait counter by one
    logic selInit;  // compare against the initial-phase limit
  } tdtStrobes_t;

endpackage

// File: rtl/tdt_datapath.sv
module tdt_datapath
  import tdt_pkg::*;
#(
  parameter int VAL_W          = 5,
  parameter int SUB_RST        = 1,
  parameter int INIT_RST       = 2,
  parameter int ASYNC_MAX      = 2,
  parameter int SUB_ASYNC_ADD  = 3,
  parameter int INIT_ASYNC_ADD = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncMode,
  input  logic             cfgWrEn,
  input  logic             cfgSelInit,
  input  logic [VAL_W-1:0] cfgWrData,
  input  tdtStrobes_t      strb,
  output logic             atLimit,
  output logic             clampSticky,
  output logic [VAL_W-1:0] subLatVal,
  output logic [VAL_W-1:0] initLatVal
);

  localparam int LIM_W = VAL_W + 1;
  localparam int NREG  = 2;
  localparam logic [LIM_W-1:0] CNT_MAX = {LIM_W{1'b1}};

  logic             wrOver;
  logic [VAL_W-1:0] wrValue;
  logic [VAL_W-1:0] storedVal [NREG];
  logic [LIM_W-1:0] effLimit  [NREG];
  logic [LIM_W-1:0] selLimit;
  logic [LIM_W-1:0] waitCnt;

  // Asynchronous mode accepts only a small range; larger values are clamped.
  assign wrOver  = !syncMode && (cfgWrData > VAL_W'(ASYNC_MAX));
  assign wrValue = wrOver ? VAL_W'(ASYNC_MAX) : cfgWrData;

  // Index 0 holds the subsequent-phase limit, index 1 the initial-phase limit.
  for (genvar g = 0; g < NREG; g++) begin : g_lim
    localparam logic [VAL_W-1:0] RST_VAL = (g == 0) ? VAL_W'(SUB_RST) : VAL_W'(INIT_RST);
    localparam logic [LIM_W-1:0] ADD_VAL = (g == 0) ? LIM_W'(SUB_ASYNC_ADD) : LIM_W'(INIT_ASYNC_ADD);

    logic             wrHit;
    logic [VAL_W-1:0] val;

    assign wrHit = cfgWrEn && (cfgSelInit == 1'(g));

    always_ff @(posedge clk) begin
      if (!rstN)      val <= RST_VAL;
      else if (wrHit) val <= wrValue;
    end

    assign storedVal[g] = val;
    assign effLimit[g]  = LIM_W'(val) + (syncMode ? '0 : ADD_VAL);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 clampSticky <= 1'b0;
    else if (cfgWrEn && wrOver) clampSticky <= 1'b1;
  end

  assign selLimit = strb.selInit ? effLimit[1] : effLimit[0];

  always_ff @(posedge clk) begin
    if (!rstN)                                  waitCnt <= '0;
    else if (strb.clrCnt)                       waitCnt <= '0;
    else if (strb.incCnt && waitCnt != CNT_MAX) waitCnt <= waitCnt + 1'b1;
  end

  assign atLimit    = (waitCnt == selLimit);
  assign subLatVal  = storedVal[0];
  assign initLatVal = storedVal[1];

endmodule

// File: rtl/tdt_ctrl.sv
module tdt_ctrl
  import tdt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        xferActive,
  input  logic        phaseDone,
  input  logic        atLimit,
  output tdtStrobes_t strb,
  output logic        discReq
);

  logic wasActive;
  logic firstPhase;
  logic fired;
  logic startPulse;
  logic restart;

  assign startPulse = xferActive && !wasActive;
  assign restart    = startPulse || phaseDone || !xferActive;

  assign discReq = xferActive && !startPulse && !phaseDone && atLimit && !fired;

  always_comb begin
    strb         = '0;
    strb.clrCnt  = restart;
    strb.incCnt  = xferActive && !restart && !atLimit;
    strb.selInit = firstPhase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wasActive  <= 1'b0;
      firstPhase <= 1'b0;
      fired      <= 1'b0;
    end else begin
      wasActive <= xferActive;

      if (!xferActive)     firstPhase <= 1'b0;
      else if (startPulse) firstPhase <= 1'b1;
      else if (phaseDone)  firstPhase <= 1'b0;

      if (restart)      fired <= 1'b0;
      else if (discReq) fired <= 1'b1;
    end
  end

endmodule

// File: rtl/tdt_latency_timer.sv
module tdt_latency_timer
  import tdt_pkg::*;
#(
  parameter int VAL_W          = 5,
  parameter int SUB_RST        = 1,
  parameter int INIT_RST       = 2,
  parameter int ASYNC_MAX      = 2,
  parameter int SUB_ASYNC_ADD  = 3,
  parameter int INIT_ASYNC_ADD = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncMode,
  input  logic             cfgWrEn,
  input  logic             cfgSelInit,
  input  logic [VAL_W-1:0] cfgWrData,
  input  logic             xferActive,
  input  logic             phaseDone,
  output logic             discReq,
  output logic             clampSticky,
  output logic [VAL_W-1:0] subLatVal,
  output logic [VAL_W-1:0] initLatVal
);

  tdtStrobes_t strb;
  logic        atLimit;

  tdt_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .xferActive (xferActive),
    .phaseDone  (phaseDone),
    .atLimit    (atLimit),
    .strb       (strb),
    .discReq    (discReq)
  );

  tdt_datapath #(
    .VAL_W          (VAL_W),
    .SUB_RST        (SUB_RST),
    .INIT_RST       (INIT_RST),
    .ASYNC_MAX      (ASYNC_MAX),
    .SUB_ASYNC_ADD  (SUB_ASYNC_ADD),
    .INIT_ASYNC_ADD (INIT_ASYNC_ADD)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .syncMode    (syncMode),
    .cfgWrEn     (cfgWrEn),
    .cfgSelInit  (cfgSelInit),
    .cfgWrData   (cfgWrData),
    .strb        (strb),
    .atLimit     (atLimit),
    .clampSticky (clampSticky),
    .subLatVal   (subLatVal),
    .initLatVal  (initLatVal)
  );

endmodule

// File: rtl/tdt_checker.sv
module tdt_checker #(
  parameter int VAL_W     = 5,
  parameter int ASYNC_MAX = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             syncMode,
  input logic             cfgWrEn,
  input logic             cfgSelInit,
  input logic [VAL_W-1:0] cfgWrData,
  input logic             xferActive,
  input logic             phaseDone,
  input logic             discReq,
  input logic             clampSticky,
  input logic [VAL_W-1:0] subLatVal,
  input logic [VAL_W-1:0] initLatVal
);

  p_sync_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && syncMode && !cfgSelInit) |=> (subLatVal == $past(cfgWrData)));

  p_clamp_sets_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !syncMode && (cfgWrData > VAL_W'(ASYNC_MAX))) |=> clampSticky);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    clampSticky |=> clampSticky);

  p_async_init_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !syncMode && cfgSelInit) |=> (initLatVal <= VAL_W'(ASYNC_MAX)));

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    discReq |=> !discReq);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !xferActive |-> !discReq);

  p_done_blocks_r10: assert property (@(posedge clk) disable iff (!rstN)
    phaseDone |-> !discReq);

endmodule

bind tdt_latency_timer tdt_checker #(
  .VAL_W     (VAL_W),
  .ASYNC_MAX (ASYNC_MAX)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .syncMode    (syncMode),
  .cfgWrEn     (cfgWrEn),
  .cfgSelInit  (cfgSelInit),
  .cfgWrData   (cfgWrData),
  .xferActive  (xferActive),
  .phaseDone   (phaseDone),
  .discReq     (discReq),
  .clampSticky (clampSticky),
  .subLatVal   (subLatVal),
  .initLatVal  (initLatVal)
);

// File: tb/tdt_latency_timer_tb.sv
module tdt_latency_timer_tb_top;

  localparam int VAL_W = 5;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             syncMode = 1'b1;
  logic             cfgWrEn = 1'b0;
  logic             cfgSelInit = 1'b0;
  logic [VAL_W-1:0] cfgWrData = '0;
  logic             xferActive = 1'b0;
  logic             phaseDone = 1'b0;
  logic             discReq;
  logic             clampSticky;
  logic [VAL_W-1:0] subLatVal;
  logic [VAL_W-1:0] initLatVal;

  int  cyc = 0;
  int  nChecks = 0;
  int  nFails = 0;
  bit  monOn = 1'b0;
  bit  doneFlag = 1'b0;

  typedef struct {
    int    cyc;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  always #4 clk = ~clk;   // 125 MHz

  always @(posedge clk) cyc <= cyc + 1;

  tdt_latency_timer dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .syncMode    (syncMode),
    .cfgWrEn     (cfgWrEn),
    .cfgSelInit  (cfgSelInit),
    .cfgWrData   (cfgWrData),
    .xferActive  (xferActive),
    .phaseDone   (phaseDone),
    .discReq     (discReq),
    .clampSticky (clampSticky),
    .subLatVal   (subLatVal),
    .initLatVal  (initLatVal)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pushExp(input int c, input string tag);
    expItem_t it;
    it.cyc = c;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compares each disconnect pulse against the scoreboard queue.
  always @(negedge clk) begin
    if (rstN && monOn) begin
      if (discReq) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected discReq at cycle", cyc, -1);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(it.cyc == cyc, it.tag, cyc, it.cyc);
        end
      end else if (expQ.size() > 0 && expQ[0].cyc < cyc) begin
        expItem_t it;
        it = expQ.pop_front();
        check(1'b0, {it.tag, " missed"}, cyc, it.cyc);
      end
    end
  end

  task automatic wrReg(input bit selInit, input int value);
    cfgWrEn    = 1'b1;
    cfgSelInit = selInit;
    cfgWrData  = VAL_W'(value);
    step();
    cfgWrEn = 1'b0;
  endtask

  // Start a transaction, let the first limit expire, complete one phase,
  // let the subsequent limit expire, then go idle.
  task automatic runXfer(input int limInit, input int limSub, input string tagI, input string tagS);
    int c0;
    int tp;
    xferActive = 1'b1;
    c0 = cyc;
    pushExp(c0 + 1 + limInit, tagI);
    step(limInit + 3);
    phaseDone = 1'b1;
    tp = cyc;
    pushExp(tp + 1 + limSub, tagS);
    step();
    phaseDone = 1'b0;
    step(limSub + 3);
    xferActive = 1'b0;
    step(4);
    check(expQ.size() == 0, "R8 scoreboard drained", expQ.size(), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!doneFlag) begin
      check(1'b0, "watchdog expired", cyc, 20000);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin : stim
    step(3);
    rstN = 1'b1;
    step();
    // R1 reset state
    check(subLatVal == 1, "R1 subsequent reset", subLatVal, 1);
    check(initLatVal == 2, "R1 initial reset", initLatVal, 2);
    check(clampSticky == 1'b0, "R1 clamp flag reset", clampSticky, 0);
    check(discReq == 1'b0, "R1 discReq reset", discReq, 0);
    monOn = 1'b1;

    // R2 register writes, synchronous mode
    wrReg(1'b0, 4);
    check(subLatVal == 4, "R2 subsequent write", subLatVal, 4);
    wrReg(1'b1, 6);
    check(initLatVal == 6, "R2 initial write", initLatVal, 6);
    check(subLatVal == 4, "R2 other register untouched", subLatVal, 4);

    // R5 / R3 synchronous limits, after R9 idle time
    step(10);
    runXfer(6, 4, "R5 sync initial", "R3 sync subsequent");

    // R3 zero subsequent limit
    wrReg(1'b0, 0);
    runXfer(6, 0, "R5 sync initial again", "R3 zero subsequent");

    // R10 phase completes exactly when the limit would expire
    wrReg(1'b0, 4);
    begin
      int tp;
      xferActive = 1'b1;
      pushExp(cyc + 1 + 6, "R5 before R10 case");
      step(9);
      phaseDone = 1'b1;
      tp = cyc;
      step();
      phaseDone = 1'b0;
      step(4);
      check(cyc == tp + 5, "R10 timing setup", cyc, tp + 5);
      phaseDone = 1'b1;
      pushExp(cyc + 1 + 4, "R10 restart after suppressed pulse");
      step();
      phaseDone = 1'b0;
      step(8);
      xferActive = 1'b0;
      step(3);
      check(expQ.size() == 0, "R10 scoreboard drained", expQ.size(), 0);
    end

    // R4 / R6 asynchronous mode
    syncMode = 1'b0;
    wrReg(1'b0, 2);
    wrReg(1'b1, 2);
    check(clampSticky == 1'b0, "R7 in-range async write no flag", clampSticky, 0);
    runXfer(16, 5, "R6 async initial 16", "R4 async subsequent");
    wrReg(1'b0, 0);
    runXfer(16, 3, "R6 async initial 16 again", "R4 async subsequent zero");

    // R7 clamping
    wrReg(1'b0, 7);
    check(subLatVal == 2, "R7 async clamp subsequent", subLatVal, 2);
    check(clampSticky == 1'b1, "R7 flag set", clampSticky, 1);
    wrReg(1'b1, 9);
    check(initLatVal == 2, "R7 async clamp initial", initLatVal, 2);
    runXfer(16, 5, "R6 after clamp", "R7 clamped limit used");

    // R7 synchronous write of a large value is stored unchanged
    syncMode = 1'b1;
    wrReg(1'b0, 9);
    check(subLatVal == 9, "R7 sync no clamp", subLatVal, 9);
    check(clampSticky == 1'b1, "R7 flag remains set", clampSticky, 1);
    runXfer(2, 9, "R5 sync initial 2", "R3 sync subsequent 9");

    doneFlag = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule